// File: doc/BRIEF.md
# Per-Destination Queue Occupancy Request Generator

This block sits in one input module of a three-stage Clos switching fabric. The input module keeps one virtual queue for each output module. For every such queue the block holds a counter of the cells waiting for that output module. Each clock cycle is one cell time slot. In a slot, up to `BATCH` cells may be written, and each write strobe carries its destination.

A queue raises its request toward the central arbiter only once it holds a full batch of `BATCH` cells. When the arbiter grants one queue in a slot, the block schedules a burst of up to `BATCH` cells toward that output module for the next slot. It reports the burst on its send outputs and takes the burst size off the counter at the same clock edge. A grant vector with more than one bit set is reported as an error and has no other effect. The cell memory and the arbiter lie outside the block.

Top module: `voqReqGen`

## Requirements
- R1: While reset is held and after it is released, every occupancy count is 0, no request bit is set, `sendValid` is 0 and `grantError` is 0.
- R2: Each set bit of `wrValid` adds exactly 1 to the queue named by its lane's destination, with no other input active. Several lanes may name the same queue in one slot. The new count is visible in the slot after the writes.
- R3: Request bit q is 1 exactly when the count of queue q in the current slot, after the last update, is at least `BATCH`.
- R4: A grant vector with exactly one bit q set in slot t causes the following in slot t+1:
  - `sendValid` = 1;
  - `sendDest` = q;
  - `sendCount` = min(count of q in slot t, `BATCH`);
  - the count of q is reduced by that amount at the same edge.
- R5: A single grant to a queue holding fewer than `BATCH` cells sends only the cells present and leaves that count at 0, unless writes arrive in the same slot. A grant to an empty queue leaves `sendValid` at 0.
- R6: When writes and a drain hit the same queue in one slot, the new count is old + writes − drained, where the drained amount is taken from the old count only.
- R7: A count never exceeds `MAX_CELLS`. Writes that would go above it are discarded and the count stays at `MAX_CELLS`.
- R8: A grant vector with two or more bits set raises `grantError` in the next slot. It causes no send and changes no count. An all-zero grant vector causes no send and no error.
- R9: The encodings are as follows:
  - `sendDest` carries the granted queue index in binary.
  - The count of queue q sits at `occCount[q*CNT_W +: CNT_W]`.
  - The destination of write lane l sits at `wrDest[l*DEST_W +: DEST_W]`.
  - Request and grant bit q both belong to queue q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cell time slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrValid | input | BATCH | One cell-write strobe per arrival lane |
| wrDest | input | BATCH*DEST_W | Destination output module for each lane |
| grantVec | input | NUM_OM | Arbiter grant for this slot, one bit per queue |
| reqVec | output | NUM_OM | Batch-ready request per queue |
| occCount | output | NUM_OM*CNT_W | Occupancy count per queue |
| sendValid | output | 1 | A burst leaves in this slot |
| sendDest | output | DEST_W | Output module of the burst |
| sendCount | output | SEND_W | Number of cells in the burst |
| grantError | output | 1 | The previous slot's grant had several bits set |

## Verification
The hardest situation to reach from the ports is a single slot in which one queue is drained and also receives new writes, while other lanes write other queues. Only then does the net-change rule show whether the drain was sized from the old count. The stimulus table builds up a small count on a queue and then writes to that queue and grants it in the same slot. A directed burst of full-width writes then pushes one queue into its ceiling, so that the clamp is reached with writes still arriving.

// File: rtl/voqReqPkg.sv
package voqReqPkg;
  localparam int IDX_W = 8;

  typedef struct packed {
    logic             drainEn;
    logic             errFlag;
    logic [IDX_W-1:0] drainIdx;
  } ctrlStrobe_t;
endpackage

// File: rtl/voqGrantCtrl.sv
module voqGrantCtrl
  import voqReqPkg::*;
#(
  parameter int NUM_OM = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_OM-1:0] grantVec,
  output ctrlStrobe_t       strobe
);
  localparam int ONES_W = $clog2(NUM_OM + 1);

  logic [ONES_W-1:0] onesCnt;
  logic [IDX_W-1:0]  encIdx;

  always_comb begin
    onesCnt = '0;
    encIdx  = '0;
    for (int i = 0; i < NUM_OM; i++) begin
      if (grantVec[i]) begin
        onesCnt = onesCnt + ONES_W'(1);
        encIdx  = IDX_W'(i);
      end
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.errFlag  = (onesCnt > ONES_W'(1));
    strobe.drainEn  = (onesCnt == ONES_W'(1));
    strobe.drainIdx = encIdx;
  end

  // R4: the encoded index must point at a set grant bit
  assert_drain_matches_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.drainEn |-> ((grantVec >> strobe.drainIdx) & NUM_OM'(1)) != '0);

  // R8: a multi-bit grant never enables a drain
  assert_no_drain_on_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(grantVec) > 1) |-> !strobe.drainEn);
endmodule

// File: rtl/voqWriteTally.sv
module voqWriteTally #(
  parameter int NUM_OM = 4,
  parameter int BATCH  = 4,
  parameter int DEST_W = 2,
  parameter int ADD_W  = 3
) (
  input  logic [BATCH-1:0]        wrValid,
  input  logic [BATCH*DEST_W-1:0] wrDest,
  output logic [ADD_W-1:0]        addCnt [NUM_OM]
);
  for (genvar q = 0; q < NUM_OM; q++) begin : g_queue
    always_comb begin
      addCnt[q] = '0;
      for (int l = 0; l < BATCH; l++) begin
        if (wrValid[l] && (wrDest[l*DEST_W +: DEST_W] == DEST_W'(q)))
          addCnt[q] = addCnt[q] + ADD_W'(1);
      end
    end
  end
endmodule

// File: rtl/voqCountPath.sv
module voqCountPath
  import voqReqPkg::*;
#(
  parameter int NUM_OM    = 4,
  parameter int BATCH     = 4,
  parameter int CNT_W     = 6,
  parameter int MAX_CELLS = 40,
  parameter int DEST_W    = 2,
  parameter int ADD_W     = 3,
  parameter int SEND_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strobe,
  input  logic [ADD_W-1:0]  addCnt [NUM_OM],
  output logic [CNT_W-1:0]  cnt [NUM_OM],
  output logic [NUM_OM-1:0] reqVec,
  output logic              sendValid,
  output logic [DEST_W-1:0] sendDest,
  output logic [SEND_W-1:0] sendCount,
  output logic              errReg
);
  localparam int SUM_W = CNT_W + 2;

  logic [SEND_W-1:0] drainAmt [NUM_OM];
  logic [SEND_W-1:0] drainTotal;

  for (genvar q = 0; q < NUM_OM; q++) begin : g_cnt
    logic [SUM_W-1:0] nextSum;

    always_comb begin
      drainAmt[q] = '0;
      if (strobe.drainEn && strobe.drainIdx == IDX_W'(q))
        drainAmt[q] = (cnt[q] >= CNT_W'(BATCH)) ? SEND_W'(BATCH) : SEND_W'(cnt[q]);
      nextSum = SUM_W'(cnt[q]) + SUM_W'(addCnt[q]) - SUM_W'(drainAmt[q]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cnt[q] <= '0;
      else if (nextSum > SUM_W'(MAX_CELLS))
        cnt[q] <= CNT_W'(MAX_CELLS);
      else
        cnt[q] <= CNT_W'(nextSum);
    end

    assign reqVec[q] = (cnt[q] >= CNT_W'(BATCH));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[q] <= CNT_W'(MAX_CELLS));

    assert_rise_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> SUM_W'(cnt[q]) <= SUM_W'($past(cnt[q])) + SUM_W'(BATCH));

    assert_fall_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> SUM_W'($past(cnt[q])) <= SUM_W'(cnt[q]) + SUM_W'(BATCH));
  end

  always_comb begin
    drainTotal = '0;
    for (int q = 0; q < NUM_OM; q++) drainTotal = drainTotal | drainAmt[q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sendValid <= 1'b0;
      sendDest  <= '0;
      sendCount <= '0;
      errReg    <= 1'b0;
    end else begin
      sendValid <= strobe.drainEn && (drainTotal != '0);
      sendDest  <= strobe.drainIdx[DEST_W-1:0];
      sendCount <= drainTotal;
      errReg    <= strobe.errFlag;
    end
  end

  // R5: a burst is never empty and never larger than a batch
  assert_burst_size_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sendValid |-> (sendCount != '0 && sendCount <= SEND_W'(BATCH)));

  // R8: an error slot carries no burst
  assert_error_blocks_send_R8: assert property (@(posedge clk) disable iff (!rst_n)
    errReg |-> !sendValid);
endmodule

// File: rtl/voqReqGen.sv
module voqReqGen
  import voqReqPkg::*;
#(
  parameter int NUM_OM    = 4,
  parameter int BATCH     = 4,
  parameter int CNT_W     = 6,
  parameter int MAX_CELLS = 40,
  parameter int DEST_W    = (NUM_OM > 1) ? $clog2(NUM_OM) : 1,
  parameter int SEND_W    = $clog2(BATCH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [BATCH-1:0]        wrValid,
  input  logic [BATCH*DEST_W-1:0] wrDest,
  input  logic [NUM_OM-1:0]       grantVec,
  output logic [NUM_OM-1:0]       reqVec,
  output logic [NUM_OM*CNT_W-1:0] occCount,
  output logic                    sendValid,
  output logic [DEST_W-1:0]       sendDest,
  output logic [SEND_W-1:0]       sendCount,
  output logic                    grantError
);
  localparam int ADD_W = $clog2(BATCH + 1);

  ctrlStrobe_t      strobe;
  logic [ADD_W-1:0] addCnt [NUM_OM];
  logic [CNT_W-1:0] cnt    [NUM_OM];

  voqGrantCtrl #(.NUM_OM(NUM_OM)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .grantVec(grantVec), .strobe(strobe)
  );

  voqWriteTally #(.NUM_OM(NUM_OM), .BATCH(BATCH), .DEST_W(DEST_W), .ADD_W(ADD_W)) u_tally (
    .wrValid(wrValid), .wrDest(wrDest), .addCnt(addCnt)
  );

  voqCountPath #(.NUM_OM(NUM_OM), .BATCH(BATCH), .CNT_W(CNT_W), .MAX_CELLS(MAX_CELLS),
                 .DEST_W(DEST_W), .ADD_W(ADD_W), .SEND_W(SEND_W)) u_path (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .addCnt(addCnt), .cnt(cnt),
    .reqVec(reqVec), .sendValid(sendValid), .sendDest(sendDest),
    .sendCount(sendCount), .errReg(grantError)
  );

  for (genvar q = 0; q < NUM_OM; q++) begin : g_flat
    assign occCount[q*CNT_W +: CNT_W] = cnt[q];
  end
endmodule

// File: tb/voqReqGen_test.sv
`timescale 1ns/1ps
module voqReqGen_test;
  localparam int NUM_OM = 4, BATCH = 4, CNT_W = 6, MAX_CELLS = 40, DEST_W = 2, SEND_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [BATCH-1:0] wrValid = '0;
  logic [BATCH*DEST_W-1:0] wrDest = '0;
  logic [NUM_OM-1:0] grantVec = '0;
  logic [NUM_OM-1:0] reqVec;
  logic [NUM_OM*CNT_W-1:0] occCount;
  logic sendValid;
  logic [DEST_W-1:0] sendDest;
  logic [SEND_W-1:0] sendCount;
  logic grantError;

  int checks = 0, errors = 0;
  int model [NUM_OM];

  always #5 clk = ~clk;

  voqReqGen uut (
    .clk(clk), .rst_n(rst_n), .wrValid(wrValid), .wrDest(wrDest), .grantVec(grantVec),
    .reqVec(reqVec), .occCount(occCount), .sendValid(sendValid), .sendDest(sendDest),
    .sendCount(sendCount), .grantError(grantError)
  );

  // stimulus vectors: {wrValid[3:0], wrDest[7:0], grantVec[3:0]}
  localparam int NVEC = 8;
  localparam logic [15:0] VEC [NVEC] = '{
    {4'b1111, 8'b00_00_00_00, 4'b0000},  // four cells into queue 0
    {4'b1111, 8'b11_10_01_01, 4'b0000},  // spread writes
    {4'b0000, 8'b00_00_00_00, 4'b0001},  // full batch drain of queue 0
    {4'b0011, 8'b00_00_01_01, 4'b0010},  // writes and drain on queue 1 together
    {4'b0000, 8'b00_00_00_00, 4'b0100},  // partial drain of queue 2
    {4'b0000, 8'b00_00_00_00, 4'b0100},  // grant on empty queue 2
    {4'b0001, 8'b00_00_00_11, 4'b0110},  // multi-bit grant with a write
    {4'b1111, 8'b11_11_11_11, 4'b0000}   // four cells into queue 3
  };

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic resetModel();
    for (int q = 0; q < NUM_OM; q++) model[q] = 0;
  endtask

  task automatic checkIdle(string tag);
    for (int q = 0; q < NUM_OM; q++)
      check(tag, int'(occCount[q*CNT_W +: CNT_W]), 0);
    check(tag, int'(reqVec), 0);
    check(tag, int'(sendValid), 0);
    check(tag, int'(grantError), 0);
  endtask

  task automatic runSlot(logic [3:0] wv, logic [7:0] wd, logic [3:0] g);
    int adds [NUM_OM];
    int ones, gq, drain, expReq;
    @(negedge clk);
    wrValid = wv; wrDest = wd; grantVec = g;
    for (int q = 0; q < NUM_OM; q++) adds[q] = 0;
    for (int l = 0; l < BATCH; l++) if (wv[l]) adds[wd[l*DEST_W +: DEST_W]]++;
    ones = 0; gq = 0;
    for (int q = 0; q < NUM_OM; q++) if (g[q]) begin ones++; gq = q; end
    drain = 0;
    if (ones == 1) drain = (model[gq] < BATCH) ? model[gq] : BATCH;
    @(posedge clk);
    #1;
    expReq = 0;
    for (int q = 0; q < NUM_OM; q++) begin
      model[q] = model[q] + adds[q] - ((ones == 1 && q == gq) ? drain : 0);
      if (model[q] > MAX_CELLS) model[q] = MAX_CELLS;
      if (model[q] >= BATCH) expReq |= (1 << q);
      check("R2/R6 count", int'(occCount[q*CNT_W +: CNT_W]), model[q]);
    end
    check("R3 request", int'(reqVec), expReq);
    check("R4/R5 sendValid", int'(sendValid), (drain > 0) ? 1 : 0);
    if (drain > 0) begin
      check("R4 sendCount", int'(sendCount), drain);
      check("R9 sendDest", int'(sendDest), gq);
    end
    check("R8 grantError", int'(grantError), (ones > 1) ? 1 : 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    resetModel();
    repeat (3) @(posedge clk);
    #1;
    checkIdle("R1 during reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    checkIdle("R1 after reset");

    for (int v = 0; v < NVEC; v++)
      runSlot(VEC[v][15:12], VEC[v][11:4], VEC[v][3:0]);

    // R7: saturation of queue 3 under sustained full-width writes
    for (int s = 0; s < 10; s++) runSlot(4'b1111, 8'b11_11_11_11, 4'b0000);
    check("R7 saturated count", int'(occCount[3*CNT_W +: CNT_W]), MAX_CELLS);

    // R5: drain from saturation removes exactly one batch
    runSlot(4'b0000, 8'h00, 4'b1000);
    check("R5 after drain", int'(occCount[3*CNT_W +: CNT_W]), MAX_CELLS - BATCH);

    // R8: zero grant causes neither send nor error
    runSlot(4'b0000, 8'h00, 4'b0000);
    // R8: all bits set is an error, counts kept
    runSlot(4'b0000, 8'h00, 4'b1111);

    // R1: reset in mid-run clears everything
    @(negedge clk);
    wrValid = '0; grantVec = '0;
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    resetModel();
    checkIdle("R1 mid-run reset");
    @(negedge clk);
    rst_n = 1'b1;
    runSlot(4'b0101, 8'b00_10_00_10, 4'b0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule